// File: doc/BRIEF.md
# Four-State DRAM Access Sequencer

This block sits on the bus side of a processor and turns one internal read or write request at a time into a DRAM access cycle. It drives a shared 13-bit address bus that carries the row address and then the column address. It drives one row strobe for each of the four address areas that can hold DRAM. Two column strobes act as upper and lower byte lanes. It also drives a write enable and an output enable that can be switched off. A wait input from the memory side can stretch the column phase.

Every accepted access runs the same base sequence of four clock states: precharge, row, first column and second column. When wait sampling is enabled for the addressed area, wait states are added between the two column states. The request also selects which row strobe fires, whether the area is 8 or 16 bits wide, and whether the output enable is used. All of these are sampled when the request is accepted. A one-cycle completion pulse follows the last column state, together with the captured read data.

Top module: `dram_seq`

## Requirements
- R1: After a synchronous active-low reset, every strobe (`ras_n_o`, `ucas_n_o`, `lcas_n_o`, `we_n_o`, `oe_n_o`) is high, and `done_o` and `dq_oe_o` are low.
- R2: A request is accepted on the clock edge where `req_i` is high and the block is idle. It is then followed by exactly four states: precharge (all strobes high), row (row strobe low, column strobes high, `ma_o` = `addr_i[25:13]`), and two column states (row and column strobes low, `ma_o` = `addr_i[12:0]`). `done_o` is high for exactly the one cycle after the second column state.
- R3: Areas 2, 3, 4 and 5 map to `ras_n_o[0]`, `[1]`, `[2]` and `[3]`. Only the strobe of the addressed area goes low, and only when `dram_en_i[area-2]` is 1. A request to any other area, or to a disabled area, is ignored: no strobe moves and `done_o` stays low.
- R4: The column strobes work as byte lanes. In an 8-bit area (`wide_i[area-2]` = 0), only `ucas_n_o` asserts. In a 16-bit area, a word access (`size_i` = 1) asserts both strobes. A byte access asserts `ucas_n_o` when `addr_i[0]` = 0 and `lcas_n_o` when `addr_i[0]` = 1.
- R5: For a write (`write_i` = 1), `we_n_o` is low and `dq_oe_o` is high from the row state through the second column state, with `dq_o` equal to the accepted `wdata_i`. For a read, `we_n_o` stays high and `dq_oe_o` stays low.
- R6: `oe_n_o` is low during the column states, including any wait states, only for a read with `oe_en_i` = 1. Otherwise it stays high.
- R7: With `wait_en_i[area-2]` = 1, a low `wait_n_i` sampled at the end of the first column state inserts a wait state. Each wait state samples again, so the number of wait states equals the number of consecutive low samples.
- R8: With `wait_en_i[area-2]` = 0, `wait_n_i` has no effect, and the access keeps exactly four states.
- R9: For a read, `dq_i` is captured on the edge that ends the second column state and appears on `rdata_o` while `done_o` is high. It holds its value until the next read completes.
- R10: A request raised while an access is in progress is ignored. It causes no further access and no extra `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, sampled when idle |
| area_i | input | 3 | Target address area |
| addr_i | input | 26 | Address: row in bits 25:13, column in bits 12:0 |
| size_i | input | 1 | 1 = 16-bit word, 0 = byte |
| write_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 16 | Write data |
| dram_en_i | input | 4 | Per-area DRAM enable (bit 0 = area 2) |
| wide_i | input | 4 | Per-area 16-bit width |
| wait_en_i | input | 4 | Per-area wait sampling enable |
| oe_en_i | input | 1 | Use output enable on reads |
| wait_n_i | input | 1 | Wait request from memory, active low |
| dq_i | input | 16 | Read data from memory |
| ma_o | output | 13 | Multiplexed row/column address |
| ras_n_o | output | 4 | Row strobes, one per area |
| ucas_n_o | output | 1 | Upper-lane column strobe |
| lcas_n_o | output | 1 | Lower-lane column strobe |
| we_n_o | output | 1 | Write enable |
| oe_n_o | output | 1 | Output enable |
| dq_o | output | 16 | Write data to memory |
| dq_oe_o | output | 1 | Drive enable for `dq_o` |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |

## Verification
The bench runs several kinds of access: a word read from a 16-bit area with the output enable on, a lower-lane byte write, and a byte read from an 8-bit area with the output enable off. Between them these separate the lane decode, the write and output-enable qualifiers, and the row strobe selection. Wait behaviour is tried with three consecutive low wait samples on an enabled area and with the wait input held low on a disabled area, which shows whether the enable bit gates sampling and whether the base length ever changes. Requests to a non-DRAM area, to a disabled area and during a running access show that ignored requests leave every strobe and the completion pulse untouched.

// File: rtl/dram_seq_pkg.sv
// Shared types for the DRAM access sequencer.
package dram_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TP   = 3'd1,
        ST_TR   = 3'd2,
        ST_TC1  = 3'd3,
        ST_TW   = 3'd4,
        ST_TC2  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/dram_seq_fsm.sv
// Access state sequencer: precharge, row, column 1, optional waits, column 2.
// Assumes start_i is only raised while idle; wait_n_i is already synchronous.
module dram_seq_fsm
    import dram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wait_en_i,
    input  logic       wait_n_i,
    output seq_state_t state_o
);
    seq_state_t state_q, state_d;

    // Next-state selection for one access.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_i) state_d = ST_TP;
            ST_TP:   state_d = ST_TR;
            ST_TR:   state_d = ST_TC1;
            ST_TC1:  state_d = (wait_en_i && !wait_n_i) ? ST_TW : ST_TC2;
            ST_TW:   state_d = (!wait_n_i) ? ST_TW : ST_TC2;
            ST_TC2:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/dram_seq_req.sv
// Request capture, area decode, row strobe and address multiplexing.
// Assumes areas FIRST_AREA..FIRST_AREA+NRAS-1 are the only ones that may be DRAM.
module dram_seq_req
    import dram_seq_pkg::*;
#(
    parameter int MA_W       = 13,
    parameter int DW         = 16,
    parameter int NRAS       = 4,
    parameter int FIRST_AREA = 2,
    parameter int AREA_W     = 3,
    localparam int ADDR_W    = 2 * MA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  seq_state_t        state_i,
    input  logic [AREA_W-1:0] area_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              size_i,
    input  logic              write_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NRAS-1:0]   dram_en_i,
    input  logic [NRAS-1:0]   wide_i,
    input  logic [NRAS-1:0]   wait_en_i,
    input  logic              oe_en_i,
    output logic              area_ok_o,
    output logic              wide_o,
    output logic              wait_en_o,
    output logic              write_o,
    output logic              word_o,
    output logic              a0_o,
    output logic              oe_en_o,
    output logic [DW-1:0]     wdata_o,
    output logic [MA_W-1:0]   ma_o,
    output logic [NRAS-1:0]   ras_n_o
);
    logic [NRAS-1:0] hit;
    logic [NRAS-1:0] sel_q;
    logic [MA_W-1:0] row_q, col_q;
    logic            ras_phase;

    // One-hot area match against the DRAM-capable window.
    for (genvar g = 0; g < NRAS; g++) begin : g_hit
        assign hit[g] = (area_i == AREA_W'(FIRST_AREA + g)) && dram_en_i[g];
    end

    assign area_ok_o = |hit;

    // Latch everything the access needs at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            row_q     <= '0;
            col_q     <= '0;
            wide_o    <= 1'b0;
            wait_en_o <= 1'b0;
            write_o   <= 1'b0;
            word_o    <= 1'b0;
            a0_o      <= 1'b0;
            oe_en_o   <= 1'b0;
            wdata_o   <= '0;
        end else if (load_i) begin
            sel_q     <= hit;
            row_q     <= addr_i[ADDR_W-1:MA_W];
            col_q     <= addr_i[MA_W-1:0];
            wide_o    <= |(wide_i & hit);
            wait_en_o <= |(wait_en_i & hit);
            write_o   <= write_i;
            word_o    <= size_i;
            a0_o      <= addr_i[0];
            oe_en_o   <= oe_en_i;
            wdata_o   <= wdata_i;
        end
    end

    assign ras_phase = (state_i == ST_TR) || (state_i == ST_TC1) ||
                       (state_i == ST_TW) || (state_i == ST_TC2);

    // Row strobe for the latched area only.
    for (genvar g = 0; g < NRAS; g++) begin : g_ras
        assign ras_n_o[g] = !(ras_phase && sel_q[g]);
    end

    // Row address up to the row state, column address from then on.
    always_comb begin
        if (state_i == ST_TP || state_i == ST_TR) ma_o = row_q;
        else                                      ma_o = col_q;
    end
endmodule

// File: rtl/dram_seq_strobe.sv
// Column strobes as byte lanes, write enable, output enable and data drive.
// Assumes lane and direction fields are stable for the whole access.
module dram_seq_strobe
    import dram_seq_pkg::*;
(
    input  seq_state_t state_i,
    input  logic       wide_i,
    input  logic       word_i,
    input  logic       a0_i,
    input  logic       write_i,
    input  logic       oe_en_i,
    output logic       ucas_n_o,
    output logic       lcas_n_o,
    output logic       we_n_o,
    output logic       oe_n_o,
    output logic       dq_oe_o
);
    logic col_phase, row_on, up_lane, lo_lane;

    // Phase flags from the sequencer state.
    always_comb begin
        col_phase = (state_i == ST_TC1) || (state_i == ST_TW) || (state_i == ST_TC2);
        row_on    = col_phase || (state_i == ST_TR);
    end

    // Lane choice: 8-bit areas use the upper lane only.
    always_comb begin
        up_lane = !wide_i || word_i || !a0_i;
        lo_lane = wide_i && (word_i || a0_i);
    end

    // Active-low strobe outputs.
    always_comb begin
        ucas_n_o = !(col_phase && up_lane);
        lcas_n_o = !(col_phase && lo_lane);
        we_n_o   = !(row_on && write_i);
        oe_n_o   = !(col_phase && !write_i && oe_en_i);
        dq_oe_o  = row_on && write_i;
    end
endmodule

// File: rtl/dram_seq_rdcap.sv
// Read data capture and completion pulse at the end of the last column state.
// Assumes dq_i is valid at the edge that ends the second column state.
module dram_seq_rdcap
    import dram_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state_i,
    input  logic          write_i,
    input  logic [DW-1:0] dq_i,
    output logic          done_o,
    output logic [DW-1:0] rdata_o
);
    // Completion pulse and read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            rdata_o <= '0;
        end else begin
            done_o <= (state_i == ST_TC2);
            if (state_i == ST_TC2 && !write_i) rdata_o <= dq_i;
        end
    end
endmodule

// File: rtl/dram_seq.sv
// Top of the four-state DRAM access sequencer.
// Assumes one request at a time; requests while busy are dropped.
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int MA_W       = 13,
    parameter int DW         = 16,
    parameter int NRAS       = 4,
    parameter int FIRST_AREA = 2,
    parameter int AREA_W     = 3,
    localparam int ADDR_W    = 2 * MA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [AREA_W-1:0] area_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              size_i,
    input  logic              write_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NRAS-1:0]   dram_en_i,
    input  logic [NRAS-1:0]   wide_i,
    input  logic [NRAS-1:0]   wait_en_i,
    input  logic              oe_en_i,
    input  logic              wait_n_i,
    input  logic [DW-1:0]     dq_i,
    output logic [MA_W-1:0]   ma_o,
    output logic [NRAS-1:0]   ras_n_o,
    output logic              ucas_n_o,
    output logic              lcas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [DW-1:0]     dq_o,
    output logic              dq_oe_o,
    output logic              done_o,
    output logic [DW-1:0]     rdata_o
);
    seq_state_t state_q;
    logic       area_ok, start;
    logic       wide_q, wait_en_q, write_q, word_q, a0_q, oe_en_q;

    assign start = req_i && area_ok && (state_q == ST_IDLE);

    dram_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .wait_en_i (wait_en_q),
        .wait_n_i  (wait_n_i),
        .state_o   (state_q)
    );

    dram_seq_req #(
        .MA_W(MA_W), .DW(DW), .NRAS(NRAS), .FIRST_AREA(FIRST_AREA), .AREA_W(AREA_W)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start),
        .state_i   (state_q),
        .area_i    (area_i),
        .addr_i    (addr_i),
        .size_i    (size_i),
        .write_i   (write_i),
        .wdata_i   (wdata_i),
        .dram_en_i (dram_en_i),
        .wide_i    (wide_i),
        .wait_en_i (wait_en_i),
        .oe_en_i   (oe_en_i),
        .area_ok_o (area_ok),
        .wide_o    (wide_q),
        .wait_en_o (wait_en_q),
        .write_o   (write_q),
        .word_o    (word_q),
        .a0_o      (a0_q),
        .oe_en_o   (oe_en_q),
        .wdata_o   (dq_o),
        .ma_o      (ma_o),
        .ras_n_o   (ras_n_o)
    );

    dram_seq_strobe u_strb (
        .state_i  (state_q),
        .wide_i   (wide_q),
        .word_i   (word_q),
        .a0_i     (a0_q),
        .write_i  (write_q),
        .oe_en_i  (oe_en_q),
        .ucas_n_o (ucas_n_o),
        .lcas_n_o (lcas_n_o),
        .we_n_o   (we_n_o),
        .oe_n_o   (oe_n_o),
        .dq_oe_o  (dq_oe_o)
    );

    dram_seq_rdcap #(.DW(DW)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state_q),
        .write_i (write_q),
        .dq_i    (dq_i),
        .done_o  (done_o),
        .rdata_o (rdata_o)
    );
endmodule

// File: rtl/dram_seq_chk.sv
// Protocol checker for the DRAM access sequencer, bound into the top.
module dram_seq_chk
    import dram_seq_pkg::*;
#(
    parameter int NRAS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input seq_state_t      state_q,
    input logic            wait_en_q,
    input logic [NRAS-1:0] ras_n_o,
    input logic            ucas_n_o,
    input logic            lcas_n_o,
    input logic            we_n_o,
    input logic            oe_n_o,
    input logic            done_o
);
    // R3
    ras_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ras_n_o));

    // R4
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ucas_n_o || !lcas_n_o) |-> (ras_n_o != '1));

    // R6
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> we_n_o);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    ras_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TR) |=> $stable(ras_n_o));

    // R8
    no_wait_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TC1 && !wait_en_q) |=> (state_q == ST_TC2));

    // R7
    wait_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TW) |-> wait_en_q);
endmodule

bind dram_seq dram_seq_chk #(.NRAS(NRAS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .wait_en_q (wait_en_q),
    .ras_n_o   (ras_n_o),
    .ucas_n_o  (ucas_n_o),
    .lcas_n_o  (lcas_n_o),
    .we_n_o    (we_n_o),
    .oe_n_o    (oe_n_o),
    .done_o    (done_o)
);

// File: tb/dram_seq_tb.sv
// Directed bench for the DRAM access sequencer.
module dram_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  area_i = '0;
    logic [25:0] addr_i = '0;
    logic        size_i = 1'b0;
    logic        write_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [3:0]  dram_en_i = '0;
    logic [3:0]  wide_i = '0;
    logic [3:0]  wait_en_i = '0;
    logic        oe_en_i = 1'b0;
    logic        wait_n_i = 1'b1;
    logic [15:0] dq_i = '0;
    logic [12:0] ma_o;
    logic [3:0]  ras_n_o;
    logic        ucas_n_o, lcas_n_o, we_n_o, oe_n_o, dq_oe_o, done_o;
    logic [15:0] dq_o, rdata_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dram_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .area_i(area_i), .addr_i(addr_i),
        .size_i(size_i), .write_i(write_i), .wdata_i(wdata_i), .dram_en_i(dram_en_i),
        .wide_i(wide_i), .wait_en_i(wait_en_i), .oe_en_i(oe_en_i), .wait_n_i(wait_n_i),
        .dq_i(dq_i), .ma_o(ma_o), .ras_n_o(ras_n_o), .ucas_n_o(ucas_n_o),
        .lcas_n_o(lcas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o), .dq_o(dq_o),
        .dq_oe_o(dq_oe_o), .done_o(done_o), .rdata_o(rdata_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] strobes();
        return {ras_n_o, ucas_n_o, lcas_n_o, we_n_o, oe_n_o};
    endfunction

    // Run one accepted access, checking every state. poke raises a second request mid-access.
    task automatic access(input string tag, input int area, input logic [25:0] addr,
                          input logic word, input logic wr, input logic [15:0] wd,
                          input logic [15:0] rd, input int nwait, input logic poke);
        int          idx  = area - 2;
        logic [3:0]  eras = ~(4'b1 << idx);
        logic        up   = !wide_i[idx] || word || !addr[0];
        logic        lo   = wide_i[idx] && (word || addr[0]);
        logic        eoe  = !(!wr && oe_en_i);
        int          ew   = wait_en_i[idx] ? nwait : 0;
        logic [7:0]  ecol = {eras, !up, !lo, !wr, eoe};
        @(negedge clk);
        req_i = 1'b1; area_i = 3'(area); addr_i = addr; size_i = word;
        write_i = wr; wdata_i = wd;
        @(negedge clk);
        req_i = 1'b0;
        check({tag, " R2 precharge strobes"}, 32'(strobes()), 32'hFF);
        @(negedge clk);
        if (poke) begin req_i = 1'b1; area_i = 3'd2; end
        check({tag, " R2 R3 R5 row strobes"}, 32'(strobes()), 32'({eras, 1'b1, 1'b1, !wr, 1'b1}));
        check({tag, " R2 row address"}, 32'(ma_o), 32'(addr[25:13]));
        check({tag, " R5 data drive"}, 32'({dq_oe_o, wr ? dq_o : 16'h0}), 32'({wr, wr ? wd : 16'h0}));
        @(negedge clk);
        req_i = 1'b0;
        check({tag, " R2 R4 R6 col1 strobes"}, 32'(strobes()), 32'(ecol));
        check({tag, " R2 column address"}, 32'(ma_o), 32'(addr[12:0]));
        wait_n_i = (nwait > 0) ? 1'b0 : 1'b1;
        for (int k = 0; k < ew; k++) begin
            @(negedge clk);
            check({tag, " R7 wait-state strobes"}, 32'({strobes(), done_o}), 32'({ecol, 1'b0}));
            wait_n_i = (k + 1 < nwait) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        check({tag, " R2 R8 col2 strobes"}, 32'({strobes(), done_o}), 32'({ecol, 1'b0}));
        dq_i = rd;
        @(negedge clk);
        wait_n_i = 1'b1;
        check({tag, " R2 done pulse, strobes idle"}, 32'({strobes(), done_o}), 32'({8'hFF, 1'b1}));
        if (!wr) check({tag, " R9 read data"}, 32'(rdata_o), 32'(rd));
        @(negedge clk);
        check({tag, " R2 done single cycle"}, 32'(done_o), 32'h0);
    endtask

    // Watch for a number of cycles that nothing moves.
    task automatic quiet(input string tag, input int cycles);
        logic moved = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (strobes() !== 8'hFF || done_o !== 1'b0) moved = 1'b1;
        end
        check({tag, " no strobe or done"}, 32'(moved), 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset strobes", 32'({strobes(), done_o, dq_oe_o}), 32'({8'hFF, 2'b00}));
    endtask

    task automatic t_word_read();
        dram_en_i = 4'hF; wide_i = 4'b0001; oe_en_i = 1'b1; wait_en_i = 4'h0;
        access("word read area2", 2, {13'h1ABC, 13'h0123}, 1'b1, 1'b0, 16'h0, 16'hBEEF, 0, 1'b0);
        quiet("R9 hold", 1);
        check("R9 rdata holds", 32'(rdata_o), 32'hBEEF);
    endtask

    task automatic t_byte_write_lo();
        wide_i = 4'b0010;
        access("byte write lower area3", 3, {13'h0F0F, 13'h0055}, 1'b0, 1'b1, 16'h5A3C, 16'h0, 0, 1'b0);
        check("R9 rdata unchanged by write", 32'(rdata_o), 32'hBEEF);
        access("byte write upper area3", 3, {13'h0001, 13'h0AA4}, 1'b0, 1'b1, 16'h1234, 16'h0, 0, 1'b0);
    endtask

    task automatic t_byte_read_narrow();
        wide_i = 4'b0000; oe_en_i = 1'b0;
        access("byte read 8-bit area4", 4, {13'h1FFF, 13'h1FFF}, 1'b0, 1'b0, 16'h0, 16'h00C7, 0, 1'b0);
    endtask

    task automatic t_wait_on();
        wide_i = 4'b1000; wait_en_i = 4'b1000; oe_en_i = 1'b1;
        access("R7 three waits area5", 5, {13'h0AAA, 13'h1555}, 1'b1, 1'b0, 16'h0, 16'h7E81, 3, 1'b0);
        access("R7 one wait write area5", 5, {13'h0002, 13'h0003}, 1'b1, 1'b1, 16'hA5A5, 16'h0, 1, 1'b0);
    endtask

    task automatic t_wait_off();
        wait_en_i = 4'b0000;
        access("R8 wait ignored area5", 5, {13'h0100, 13'h0200}, 1'b1, 1'b0, 16'h0, 16'h4321, 4, 1'b0);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        req_i = 1'b1; area_i = 3'd1; write_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        quiet("R3 area1 ignored", 8);
        dram_en_i = 4'b1101;
        @(negedge clk);
        req_i = 1'b1; area_i = 3'd3;
        @(negedge clk);
        req_i = 1'b0;
        quiet("R3 disabled area3 ignored", 8);
        dram_en_i = 4'hF;
    endtask

    task automatic t_busy();
        wide_i = 4'b0001; oe_en_i = 1'b1;
        access("R10 busy poke", 4, {13'h0033, 13'h0044}, 1'b0, 1'b0, 16'h0, 16'h0F0F, 0, 1'b1);
        quiet("R10 poke dropped", 8);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word_read();
        t_byte_write_lo();
        t_byte_read_narrow();
        t_wait_on();
        t_wait_off();
        t_ignore();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule